// File: doc/BRIEF.md
# Serial Configuration Streamer

This controller is the configuration source for a programmable target. It reads a stored bitstream one bit at a time through a simple address/read-strobe memory port. Each bit goes out on a serial data line, paced by a serial clock that is derived from the system clock. Once the last bit has been sent, the controller keeps the serial clock running for a bounded window while it watches the target's done line. A high done ends the transfer: the clock is parked low and the data line is either held high or released.

The controller's enable input is wired to an open-drain line that it shares with the target's status pin. A low on that line from either side stops the controller and returns it to idle. If done never arrives, the controller pulls the shared line low for a single system clock, which resets the target. The target then keeps the line low for its own reset timeout. When the line rises again, the controller restreams the bitstream from address zero. The window length and the end-of-transfer data behaviour are chosen by a legacy mode parameter.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: During reset and while idle, the serial clock is low, serial data is high, the data output enable is high, the shared-line pull is low, and the memory read strobe is low.
- R2: One stream sends the memory bits at addresses 0 through TOTAL_BITS-1, in increasing address order and one bit per rising serial clock edge. The memory read strobe is high while bits are being sent.
- R3: The serial clock period is 2*HALF_DIV system clocks. While a stream runs, serial data changes only in cycles where the serial clock is low.
- R4: After the last bit, the serial clock keeps running. If done goes high inside the window, the controller finishes without pulling the shared line.
- R5: With LEGACY=0 and done held low, the shared-line pull asserts after exactly TOTAL_BITS+64 rising serial clock edges, counted from the start of the stream.
- R6: Each shared-line pull lasts exactly one system clock.
- R7: A low driven onto the shared line from outside stops the serial clock within a few system clocks. This holds while streaming, while waiting, and after success. When the line returns high, streaming restarts at address 0.
- R8: After a failure pull, the controller stays idle with no serial clock edges while the target holds the line low. It restreams from address 0 when the line is released.
- R9: After success, the serial clock is parked low, data is high, the output enable is high, and no further serial clock edges occur.
- R10: With LEGACY=1, the window is 16 rising serial clock edges, and after success the data output enable is low (data tri-stated).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | ADDR_W | Bit address presented to the bitstream memory |
| mem_rd_o | output | 1 | Memory read strobe, high while streaming |
| mem_bit_i | input | 1 | Bit read from the memory at mem_addr_o (combinational read) |
| sclk_o | output | 1 | Serial configuration clock |
| sdata_o | output | 1 | Serial configuration data |
| sdata_oe_o | output | 1 | Output enable for serial data (low means tri-state) |
| done_i | input | 1 | Target done line (asynchronous) |
| line_i | input | 1 | Sensed level of the shared enable/status line (asynchronous) |
| line_pull_o | output | 1 | Pulls the shared line low when high (open-drain control) |

## Verification
The hardest case to reach from the ports is the restart after a failure. The line falls because of the controller's own one-cycle pull, and then the target holds it low. The restart must follow the target's release, not the controller's own release. The bench models the target as an open-drain partner: any pull it sees starts a 30-cycle hold. A done-less stream therefore runs through the full window into the failure pull and its restart. A second case aborts a stream after fifteen bits with an external low and switches the memory pattern while the line is low. This shows that the restarted bits come from address zero, not from the abort point.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_STREAM = 3'd1,
    ST_WAIT   = 3'd2,
    ST_FAIL   = 3'd3,
    ST_DONE   = 3'd4
  } stream_state_t;

endpackage

// File: rtl/cfg_stream_sync.sv
module cfg_stream_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_stream_clkdiv.sv
module cfg_stream_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          edge_w;

  assign edge_w = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (edge_w) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = edge_w && sclk_q;

  // R1: a stopped divider leaves the serial clock low
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !sclk_o);

  // R3: the clock only toggles after a full half period of counting
  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !$stable(sclk_o) && sclk_o) |-> ($past(cnt_q) == CW'(HALF_DIV - 1)));

endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl
  import cfg_stream_pkg::*;
#(
  parameter int TOTAL_BITS  = 40,
  parameter int HALF_DIV    = 2,
  parameter int LEGACY      = 0,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic              mem_bit_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  input  logic              done_i,
  input  logic              line_i,
  output logic              line_pull_o
);

  localparam int WIN = (LEGACY != 0) ? 16 : 64;
  localparam int WW  = $clog2(WIN + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(TOTAL_BITS - 1);

  if (TOTAL_BITS < 1) begin : g_bad_len
    $error("TOTAL_BITS must be at least one");
  end

  stream_state_t     state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WW-1:0]     wcnt_q, wcnt_d;
  logic              low_seen_q, low_seen_d;
  logic              done_s, line_s;
  logic              run_w, fall_w;

  cfg_stream_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({done_i, line_i}),
    .sync_o  ({done_s, line_s})
  );

  assign run_w = (state_q == ST_STREAM) || (state_q == ST_WAIT);

  cfg_stream_clkdiv #(
    .HALF_DIV (HALF_DIV)
  ) u_clkdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_w),
    .sclk_o (sclk_o),
    .fall_o (fall_w)
  );

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    wcnt_d     = wcnt_q;
    low_seen_d = low_seen_q;
    unique case (state_q)
      ST_HOLD: begin
        addr_d = '0;
        wcnt_d = '0;
        if (!line_s) begin
          low_seen_d = 1'b1;
        end else if (low_seen_q) begin
          state_d = ST_STREAM;
        end
      end
      ST_STREAM: begin
        if (!line_s) begin
          state_d    = ST_HOLD;
          low_seen_d = 1'b1;
        end else if (fall_w) begin
          if (addr_q == LAST_ADDR) begin
            state_d = ST_WAIT;
            wcnt_d  = '0;
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!line_s) begin
          state_d    = ST_HOLD;
          low_seen_d = 1'b1;
        end else if (done_s) begin
          state_d = ST_DONE;
        end else if (fall_w) begin
          if (wcnt_q == WW'(WIN - 1)) begin
            state_d = ST_FAIL;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_FAIL: begin
        state_d    = ST_HOLD;
        low_seen_d = 1'b0;
      end
      ST_DONE: begin
        if (!line_s) begin
          state_d    = ST_HOLD;
          low_seen_d = 1'b1;
        end
      end
      default: begin
        state_d = ST_HOLD;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HOLD;
      addr_q     <= '0;
      wcnt_q     <= '0;
      low_seen_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      addr_q     <= addr_d;
      wcnt_q     <= wcnt_d;
      low_seen_q <= low_seen_d;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = (state_q == ST_STREAM);
  assign sdata_o     = (state_q == ST_STREAM) ? mem_bit_i : 1'b1;
  assign line_pull_o = (state_q == ST_FAIL);

  if (LEGACY != 0) begin : g_tristate_end
    assign sdata_oe_o = (state_q != ST_DONE);
  end else begin : g_drive_end
    assign sdata_oe_o = 1'b1;
  end

  // R3: bit changes happen only while the serial clock is low
  assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STREAM && $past(state_q) == ST_STREAM && !$stable(sdata_o)) |-> !sclk_o);

  // R5: failure only after the last window count of the wait phase
  assert_window_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL) |-> ($past(state_q) == ST_WAIT && $past(wcnt_q) == WW'(WIN - 1)));

  // R6: the pull on the shared line is a single cycle
  assert_pull_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_o |=> !line_pull_o);

  // R7: every new stream begins at the first bit
  assert_restart_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STREAM && $past(state_q) != ST_STREAM) |-> (addr_q == '0));

  // R8: a low shared line halts memory reads
  assert_line_low_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_s |=> !mem_rd_o);

  // R9: a finished transfer stays parked
  assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> (!sclk_o && sdata_o));

endmodule

// File: tb/cfg_stream_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_stream_ctrl_bench;

  localparam int TB  = 40;
  localparam int HD  = 2;
  localparam int LTB = 24;
  localparam int LHD = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [5:0] mem_addr;
  logic       mem_rd, mem_bit, sclk, sdata, oe, done_in, line, pull;
  logic       host_pull;
  int         pat_sel;
  int         hold_cnt = 0;

  logic [4:0] addr_l;
  logic       rd_l, bit_l, sclk_l, sdata_l, oe_l, done_l, line_l, pull_l;

  int checks = 0;
  int errors = 0;

  function automatic logic pat_bit(input int sel, input int a);
    case (sel)
      0:       return ((a * 7 + 3) % 5) < 2;
      1:       return ((a * 3 + 1) % 4) >= 2;
      default: return (a == 0) || (a == TB - 1) || ((a % 6) == 3);
    endcase
  endfunction

  assign mem_bit = pat_bit(pat_sel, int'(mem_addr));
  assign line    = !(pull || host_pull || (hold_cnt != 0));
  assign bit_l   = pat_bit(0, int'(addr_l));
  assign line_l  = !pull_l;

  cfg_stream_ctrl #(.TOTAL_BITS(TB), .HALF_DIV(HD), .LEGACY(0)) u_cfg_stream_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_bit_i(mem_bit), .sclk_o(sclk), .sdata_o(sdata), .sdata_oe_o(oe),
    .done_i(done_in), .line_i(line), .line_pull_o(pull));

  cfg_stream_ctrl #(.TOTAL_BITS(LTB), .HALF_DIV(LHD), .LEGACY(1)) u_cfg_stream_ctrl_legacy (
    .clk(clk), .rst_n(rst_n), .mem_addr_o(addr_l), .mem_rd_o(rd_l),
    .mem_bit_i(bit_l), .sclk_o(sclk_l), .sdata_o(sdata_l), .sdata_oe_o(oe_l),
    .done_i(done_l), .line_i(line_l), .line_pull_o(pull_l));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard state
  logic exp_q[$];
  bit   ignore = 1'b0;
  int   run_rises = 0;
  int   idx = 0;
  int   t_first = 0;
  int   cyc = 0;
  int   pull_len = 0;
  int   pull_cnt = 0;
  int   glitches = 0;
  logic prev_sclk = 1'b0;
  logic prev_sdata = 1'b1;

  task automatic push_stream(input int sel);
    exp_q.delete();
    for (int a = 0; a < TB; a++) exp_q.push_back(pat_bit(sel, a));
    idx = 0;
  endtask

  // target model: any pull starts a reset hold on the shared line
  always @(negedge clk) begin
    if (pull) hold_cnt = 30;
    else if (hold_cnt > 0) hold_cnt = hold_cnt - 1;
  end

  // monitor: pops expected bits at every rising serial clock edge
  always @(negedge clk) begin
    logic e;
    cyc++;
    if (rst_n) begin
      if (sclk && !prev_sclk) begin
        run_rises++;
        if (!ignore && exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check(sdata == e, "R2 bit order", int'(sdata), int'(e));
          idx++;
          if (idx == 1) t_first = cyc;
          if (idx == 2) check(cyc - t_first == 2 * HD, "R3 period", cyc - t_first, 2 * HD);
        end
      end
      if (sclk && prev_sclk && sdata != prev_sdata) glitches++;
      if (pull) pull_len++;
      else if (pull_len > 0) begin
        check(pull_len == 1, "R6 pull width", pull_len, 1);
        pull_cnt++;
        pull_len = 0;
      end
    end
    prev_sclk  = sclk;
    prev_sdata = sdata;
  end

  // legacy instance monitor
  int   l_rises = 0, l_idx = 0, l_bit_err = 0, l_pull_cnt = 0, l_rises_at_pull = 0;
  logic l_prev_sclk = 1'b0, l_prev_pull = 1'b0;
  bit   l_finished = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_l && !l_prev_sclk) begin
        if (l_idx < LTB && sdata_l != pat_bit(0, l_idx)) l_bit_err++;
        l_idx++;
        l_rises++;
      end
      if (pull_l && !l_prev_pull) begin
        l_pull_cnt++;
        l_rises_at_pull = l_rises;
        l_rises = 0;
        l_idx = 0;
      end
    end
    l_prev_sclk = sclk_l;
    l_prev_pull = pull_l;
  end

  initial begin
    done_l = 1'b0;
    @(posedge rst_n);
    while (l_pull_cnt < 1) @(negedge clk);
    check(l_rises_at_pull == LTB + 16, "R10 legacy window", l_rises_at_pull, LTB + 16);
    done_l = 1'b1;
    wait_cycles(300);
    check(l_pull_cnt == 1, "R10 no second pull", l_pull_cnt, 1);
    check(l_rises == LTB, "R10 restream length", l_rises, LTB);
    check(oe_l == 1'b0, "R10 data tri-stated", int'(oe_l), 0);
    check(sclk_l == 1'b0, "R10 clock parked", int'(sclk_l), 0);
    check(l_bit_err == 0, "R2 legacy bits", l_bit_err, 0);
    l_finished = 1'b1;
  end

  task automatic run_main();
    int r;
    rst_n = 1'b0; host_pull = 1'b0; done_in = 1'b0; pat_sel = 0;
    wait_cycles(5);
    check(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
    check(sdata == 1'b1, "R1 reset data", int'(sdata), 1);
    check(oe == 1'b1, "R1 reset oe", int'(oe), 1);
    check(pull == 1'b0, "R1 reset pull", int'(pull), 0);
    check(mem_rd == 1'b0, "R1 reset read", int'(mem_rd), 0);
    push_stream(0);
    run_rises = 0;
    rst_n = 1'b1;

    // done never arrives: full window then failure pull
    while (pull_cnt < 1) @(negedge clk);
    check(run_rises == TB + 64, "R5 rises before pull", run_rises, TB + 64);
    check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
    r = run_rises;
    wait_cycles(15);
    check(run_rises == r, "R8 idle while held", run_rises, r);
    check(mem_rd == 1'b0, "R8 no read while held", int'(mem_rd), 0);
    pat_sel = 1;
    push_stream(1);
    run_rises = 0;

    // restream after the target releases, done inside the window
    while (exp_q.size() != 0) @(negedge clk);
    while (run_rises < TB + 10) @(negedge clk);
    done_in = 1'b1;
    wait_cycles(40);
    check(run_rises >= TB + 10 && run_rises <= TB + 12, "R4 stop after done", run_rises, TB + 10);
    check(pull_cnt == 1, "R4 no pull on success", pull_cnt, 1);
    check(sclk == 1'b0, "R9 clock parked", int'(sclk), 0);
    check(sdata == 1'b1, "R9 data high", int'(sdata), 1);
    check(oe == 1'b1, "R9 data driven", int'(oe), 1);
    r = run_rises;
    wait_cycles(100);
    check(run_rises == r, "R9 no more edges", run_rises, r);

    // external low after success restarts from address 0
    host_pull = 1'b1;
    done_in = 1'b0;
    wait_cycles(10);
    check(mem_rd == 1'b0 && sclk == 1'b0, "R7 halted by low line", int'(mem_rd), 0);
    pat_sel = 2;
    push_stream(2);
    run_rises = 0;
    host_pull = 1'b0;

    // abort mid-stream after fifteen bits
    while (exp_q.size() > TB - 15) @(negedge clk);
    host_pull = 1'b1;
    ignore = 1'b1;
    exp_q.delete();
    wait_cycles(5);
    r = run_rises;
    wait_cycles(20);
    check(run_rises == r, "R7 clock stops on low", run_rises, r);
    check(sclk == 1'b0, "R7 clock low when stopped", int'(sclk), 0);
    pat_sel = 0;
    push_stream(0);
    run_rises = 0;
    ignore = 1'b0;
    host_pull = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    while (run_rises < TB + 5) @(negedge clk);
    done_in = 1'b1;
    wait_cycles(40);
    check(run_rises <= TB + 7, "R4 early done", run_rises, TB + 5);
    check(pull_cnt == 1, "R7 no pull after abort", pull_cnt, 1);

    while (!l_finished) @(negedge clk);
    check(glitches == 0, "R3 data steady while high", glitches, 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule